// File: doc/BRIEF.md
# I2C First-Failure Transaction Capture

This block sits beside an I2C controller and builds a context record for every bus transaction from strobes that the controller raises: START seen, each byte moved, transaction finished. A record holds a timestamp taken at START, a transaction ID, the 7-bit target address and R/W bit, the first byte after the address (register or command), the number of bytes after the address, the timeout bucket and attempt number reported at the end, the longest continuous SCL low-hold seen inside the transaction, and whether the bus was idle at START and at the end.

Records go into a circular history. At the end of a transaction the record is tested against a trigger. The trigger fires on a nonzero timeout bucket or on a low-hold longer than a programmable limit. An optional address match and an optional command match can narrow it. The first qualifying transaction is stored as the newest entry, and the history then freezes. Later retries therefore cannot push out the failing transaction or the ones that led up to it. Software walks the frozen history from oldest to newest with a step input. A re-arm pulse empties the history and resumes capture. The transaction ID keeps counting, so it still matches firmware logs.

Top module: `i2c_fail_capture`

## Requirements
- R1: After reset, `frozen` is 0 and `rec_count` is 0.
- R2: `rd_record` is 95 bits. From the MSB down it holds: timestamp [94:63], transaction ID [62:47], address [46:40], R/W [39], command byte [38:31], length [30:23], bucket [22:21], attempt [20:18], max low-hold [17:2], idle-at-START [1], idle-at-end [0]. The timestamp is the value of a free-running cycle counter (0 on the first cycle after reset) at the START strobe. The first byte after START gives address and R/W as {addr[6:0], rw}. The command is the next byte, or 0 if there is none. The length counts the bytes after the address byte. Bucket, attempt and idle-at-end are taken with the end strobe.
- R3: The transaction ID is 0 for the first START after reset and rises by 1 at every START, including while frozen.
- R4: Max low-hold is the longest run of consecutive clock cycles with `scl_held` high between the START and end strobes.
- R5: A transaction qualifies when its bucket is nonzero or its max low-hold is greater than `hold_limit`, subject to the filters. It is stored, and `frozen` goes to 1. A low-hold equal to the limit does not qualify.
- R6: While frozen, finishing transactions store nothing, and `rec_count` and the stored records do not change.
- R7: With `addr_filt_en` set, only transactions whose address equals `addr_filt` can qualify. With `cmd_filt_en` set, only those whose command equals `cmd_filt` can qualify.
- R8: The history keeps the last 8 records, and `rec_count` saturates at 8. After a freeze, `rd_record` shows the oldest record. Each `rd_step` moves to the next newer record and wraps from the newest back to the oldest.
- R9: A `rearm` pulse clears `frozen`, empties the history and resets the read position. It does not reset the transaction ID.
- R10: A failing transaction that the filters exclude is still stored in the history but does not freeze it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| txn_start | input | 1 | START seen (one-cycle pulse) |
| byte_valid | input | 1 | A byte was transferred |
| byte_data | input | 8 | Transferred byte |
| scl_held | input | 1 | SCL is being held low by a target |
| bus_idle | input | 1 | Bus idle level |
| txn_end | input | 1 | Transaction finished (one-cycle pulse) |
| end_bucket | input | 2 | Timeout bucket, 0 = none |
| end_attempt | input | 3 | Attempt number |
| hold_limit | input | 16 | Low-hold trigger limit in cycles |
| addr_filt_en | input | 1 | Enable address filter |
| addr_filt | input | 7 | Address to match |
| cmd_filt_en | input | 1 | Enable command filter |
| cmd_filt | input | 8 | Command to match |
| rearm | input | 1 | Clear frozen state and history |
| rd_step | input | 1 | Advance read position |
| frozen | output | 1 | First failure captured |
| rec_count | output | 4 | Records held |
| rd_record | output | 95 | Record at read position |

## Verification
The record written by a transaction's end strobe, along with the resulting `frozen` and `rec_count`, becomes visible one clock edge after that strobe. `rd_record` is decoded from registers, so it follows an `rd_step` one edge later. The bench drives every input on the falling edge and samples each result on the next falling edge, half a cycle after the edge that produces it. The expected timestamp comes from a bench cycle counter that starts at the same reset release, read on the falling edge before the START edge. The expected low-hold is counted from the rising edges on which `scl_held` was driven high.

// File: rtl/fcap_pkg.sv
package fcap_pkg;
    localparam int TS_W   = 32;
    localparam int ID_W   = 16;
    localparam int HOLD_W = 16;
    localparam int LEN_W  = 8;
    localparam int BKT_W  = 2;
    localparam int ATT_W  = 3;

    typedef struct packed {
        logic [TS_W-1:0]   ts;
        logic [ID_W-1:0]   txn_id;
        logic [6:0]        addr;
        logic              rd;
        logic [7:0]        cmd;
        logic [LEN_W-1:0]  len;
        logic [BKT_W-1:0]  bucket;
        logic [ATT_W-1:0]  attempt;
        logic [HOLD_W-1:0] max_hold;
        logic              idle_before;
        logic              idle_after;
    } fcap_rec_t;

    localparam int REC_W = $bits(fcap_rec_t);

    function automatic logic [HOLD_W-1:0] hold_inc(input logic [HOLD_W-1:0] v);
        return (v == {HOLD_W{1'b1}}) ? v : v + 1'b1;
    endfunction

    function automatic logic [LEN_W-1:0] len_inc(input logic [LEN_W-1:0] v);
        return (v == {LEN_W{1'b1}}) ? v : v + 1'b1;
    endfunction
endpackage

// File: rtl/fcap_tracker.sv
module fcap_tracker
    import fcap_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 txn_start,
    input  logic                 byte_valid,
    input  logic [7:0]           byte_data,
    input  logic                 scl_held,
    input  logic                 bus_idle,
    input  logic                 txn_end,
    input  logic [BKT_W-1:0]     end_bucket,
    input  logic [ATT_W-1:0]     end_attempt,
    output fcap_rec_t            rec
);
    logic [TS_W-1:0]   ts_cnt;
    logic [ID_W-1:0]   id_cnt;
    logic              active;
    logic              got_addr;
    logic [TS_W-1:0]   ts_q;
    logic [ID_W-1:0]   id_q;
    logic [6:0]        addr_q;
    logic              rd_q;
    logic [7:0]        cmd_q;
    logic [LEN_W-1:0]  len_q;
    logic              idle_b_q;
    logic [HOLD_W-1:0] run_q;
    logic [HOLD_W-1:0] max_q;
    logic [HOLD_W-1:0] run_n;

    always_comb run_n = scl_held ? hold_inc(run_q) : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            ts_cnt   <= '0;
            id_cnt   <= '0;
            active   <= 1'b0;
            got_addr <= 1'b0;
            ts_q     <= '0;
            id_q     <= '0;
            addr_q   <= '0;
            rd_q     <= 1'b0;
            cmd_q    <= '0;
            len_q    <= '0;
            idle_b_q <= 1'b0;
            run_q    <= '0;
            max_q    <= '0;
        end else begin
            ts_cnt <= ts_cnt + 1'b1;
            if (txn_start) begin
                active   <= 1'b1;
                got_addr <= 1'b0;
                ts_q     <= ts_cnt;
                id_q     <= id_cnt;
                id_cnt   <= id_cnt + 1'b1;
                addr_q   <= '0;
                rd_q     <= 1'b0;
                cmd_q    <= '0;
                len_q    <= '0;
                idle_b_q <= bus_idle;
                run_q    <= '0;
                max_q    <= '0;
            end else if (active) begin
                if (txn_end) active <= 1'b0;
                if (byte_valid) begin
                    if (!got_addr) begin
                        got_addr <= 1'b1;
                        addr_q   <= byte_data[7:1];
                        rd_q     <= byte_data[0];
                    end else begin
                        if (len_q == '0) cmd_q <= byte_data;
                        len_q <= len_inc(len_q);
                    end
                end
                run_q <= run_n;
                if (run_n > max_q) max_q <= run_n;
            end
        end
    end

    always_comb begin
        rec.ts          = ts_q;
        rec.txn_id      = id_q;
        rec.addr        = addr_q;
        rec.rd          = rd_q;
        rec.cmd         = cmd_q;
        rec.len         = len_q;
        rec.bucket      = end_bucket;
        rec.attempt     = end_attempt;
        rec.max_hold    = max_q;
        rec.idle_before = idle_b_q;
        rec.idle_after  = bus_idle;
    end

    // R3
    id_step_chk: assert property (@(posedge clk) disable iff (rst)
        !txn_start |=> $stable(id_cnt));

    // R4
    hold_order_chk: assert property (@(posedge clk) disable iff (rst)
        run_q <= max_q);
endmodule

// File: rtl/fcap_trigger.sv
module fcap_trigger
    import fcap_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  fcap_rec_t         rec,
    input  logic              txn_end,
    input  logic [HOLD_W-1:0] hold_limit,
    input  logic              addr_filt_en,
    input  logic [6:0]        addr_filt,
    input  logic              cmd_filt_en,
    input  logic [7:0]        cmd_filt,
    output logic              hit
);
    logic failed;
    logic addr_ok;
    logic cmd_ok;

    always_comb begin
        failed  = (rec.bucket != '0) || (rec.max_hold > hold_limit);
        addr_ok = !addr_filt_en || (rec.addr == addr_filt);
        cmd_ok  = !cmd_filt_en  || (rec.cmd  == cmd_filt);
        hit     = failed && addr_ok && cmd_ok;
    end

    // R7
    addr_block_chk: assert property (@(posedge clk) disable iff (rst)
        (txn_end && addr_filt_en && rec.addr != addr_filt) |-> !hit);

    // R5
    bucket_fire_chk: assert property (@(posedge clk) disable iff (rst)
        (txn_end && rec.bucket != '0 && !addr_filt_en && !cmd_filt_en) |-> hit);
endmodule

// File: rtl/fcap_history.sv
module fcap_history
    import fcap_pkg::*;
#(
    parameter int DEPTH = 8
) (
    input  logic                       clk,
    input  logic                       rst,
    input  fcap_rec_t                  rec_in,
    input  logic                       txn_end,
    input  logic                       hit,
    input  logic                       rearm,
    input  logic                       rd_step,
    output logic                       frozen,
    output logic [$clog2(DEPTH+1)-1:0] count,
    output fcap_rec_t                  rd_rec
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH+1);
    localparam logic [CNT_W-1:0] FULL = CNT_W'(DEPTH);

    fcap_rec_t         mem [DEPTH];
    logic [PTR_W-1:0]  wr_ptr;
    logic [CNT_W-1:0]  rd_off;
    logic              wr_en;
    logic [PTR_W-1:0]  oldest;
    logic [PTR_W:0]    idx_sum;
    logic [PTR_W-1:0]  rd_idx;

    assign wr_en = txn_end && !frozen && !rearm;

    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        always_ff @(posedge clk) begin
            if (wr_en && wr_ptr == PTR_W'(g)) mem[g] <= rec_in;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || rearm) begin
            frozen <= 1'b0;
            count  <= '0;
            wr_ptr <= '0;
            rd_off <= '0;
        end else begin
            if (wr_en) begin
                wr_ptr <= (wr_ptr == PTR_W'(DEPTH-1)) ? '0 : wr_ptr + 1'b1;
                if (count != FULL) count <= count + 1'b1;
            end
            if (wr_en && hit) begin
                frozen <= 1'b1;
                rd_off <= '0;
            end else if (rd_step && count != '0) begin
                rd_off <= (rd_off == count - 1'b1) ? '0 : rd_off + 1'b1;
            end
        end
    end

    always_comb begin
        oldest  = (count == FULL) ? wr_ptr : '0;
        idx_sum = {1'b0, oldest} + (PTR_W+1)'(rd_off);
        if (idx_sum >= (PTR_W+1)'(DEPTH)) idx_sum = idx_sum - (PTR_W+1)'(DEPTH);
        rd_idx  = idx_sum[PTR_W-1:0];
        rd_rec  = (count == '0) ? '0 : mem[rd_idx];
    end

    // R6
    frozen_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (frozen && !rearm) |=> frozen);

    // R6
    frozen_nowrite_chk: assert property (@(posedge clk) disable iff (rst)
        (frozen && !rearm) |=> ($stable(count) && $stable(wr_ptr)));

    // R5
    freeze_cause_chk: assert property (@(posedge clk) disable iff (rst)
        (!frozen && !(txn_end && hit)) |=> !frozen);

    // R8
    count_bound_chk: assert property (@(posedge clk) disable iff (rst)
        count <= FULL);

    // R8
    rd_range_chk: assert property (@(posedge clk) disable iff (rst)
        (count != '0) |-> (rd_off < count));
endmodule

// File: rtl/i2c_fail_capture.sv
module i2c_fail_capture
    import fcap_pkg::*;
#(
    parameter int DEPTH = 8
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       txn_start,
    input  logic                       byte_valid,
    input  logic [7:0]                 byte_data,
    input  logic                       scl_held,
    input  logic                       bus_idle,
    input  logic                       txn_end,
    input  logic [BKT_W-1:0]           end_bucket,
    input  logic [ATT_W-1:0]           end_attempt,
    input  logic [HOLD_W-1:0]          hold_limit,
    input  logic                       addr_filt_en,
    input  logic [6:0]                 addr_filt,
    input  logic                       cmd_filt_en,
    input  logic [7:0]                 cmd_filt,
    input  logic                       rearm,
    input  logic                       rd_step,
    output logic                       frozen,
    output logic [$clog2(DEPTH+1)-1:0] rec_count,
    output logic [REC_W-1:0]           rd_record
);
    fcap_rec_t cur_rec;
    fcap_rec_t out_rec;
    logic      hit;

    fcap_tracker u_tracker (
        .clk         (clk),
        .rst         (rst),
        .txn_start   (txn_start),
        .byte_valid  (byte_valid),
        .byte_data   (byte_data),
        .scl_held    (scl_held),
        .bus_idle    (bus_idle),
        .txn_end     (txn_end),
        .end_bucket  (end_bucket),
        .end_attempt (end_attempt),
        .rec         (cur_rec)
    );

    fcap_trigger u_trigger (
        .clk          (clk),
        .rst          (rst),
        .rec          (cur_rec),
        .txn_end      (txn_end),
        .hold_limit   (hold_limit),
        .addr_filt_en (addr_filt_en),
        .addr_filt    (addr_filt),
        .cmd_filt_en  (cmd_filt_en),
        .cmd_filt     (cmd_filt),
        .hit          (hit)
    );

    fcap_history #(.DEPTH(DEPTH)) u_history (
        .clk     (clk),
        .rst     (rst),
        .rec_in  (cur_rec),
        .txn_end (txn_end),
        .hit     (hit),
        .rearm   (rearm),
        .rd_step (rd_step),
        .frozen  (frozen),
        .count   (rec_count),
        .rd_rec  (out_rec)
    );

    assign rd_record = out_rec;
endmodule

// File: tb/test_i2c_fail_capture.sv
module test_i2c_fail_capture;
    import fcap_pkg::*;

    localparam int DEPTH = 8;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic txn_start = 0, byte_valid = 0, scl_held = 0, bus_idle = 1, txn_end = 0;
    logic [7:0] byte_data = 0;
    logic [1:0] end_bucket = 0;
    logic [2:0] end_attempt = 0;
    logic [15:0] hold_limit = 16'd20;
    logic addr_filt_en = 0, cmd_filt_en = 0, rearm = 0, rd_step = 0;
    logic [6:0] addr_filt = 0;
    logic [7:0] cmd_filt = 0;
    logic frozen;
    logic [3:0] rec_count;
    logic [REC_W-1:0] rd_record;

    int checks = 0;
    int failures = 0;
    bit done = 0;
    logic [31:0] cyc;
    int next_id = 0;
    bit m_frozen = 0;
    fcap_rec_t m_q[$];

    always #2 clk = ~clk;

    always_ff @(posedge clk) begin
        if (rst) cyc <= '0;
        else     cyc <= cyc + 1;
    end

    i2c_fail_capture #(.DEPTH(DEPTH)) i_i2c_fail_capture (
        .clk(clk), .rst(rst), .txn_start(txn_start), .byte_valid(byte_valid),
        .byte_data(byte_data), .scl_held(scl_held), .bus_idle(bus_idle),
        .txn_end(txn_end), .end_bucket(end_bucket), .end_attempt(end_attempt),
        .hold_limit(hold_limit), .addr_filt_en(addr_filt_en), .addr_filt(addr_filt),
        .cmd_filt_en(cmd_filt_en), .cmd_filt(cmd_filt), .rearm(rearm),
        .rd_step(rd_step), .frozen(frozen), .rec_count(rec_count), .rd_record(rd_record)
    );

    task automatic chk(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic bit model_hit(fcap_rec_t r);
        bit bad = (r.bucket != 0) || (r.max_hold > hold_limit);
        bit aok = !addr_filt_en || (r.addr == addr_filt);
        bit cok = !cmd_filt_en || (r.cmd == cmd_filt);
        return bad && aok && cok;
    endfunction

    // one transaction; h1/h2 are two separate SCL low-hold runs
    task automatic run_txn(input logic [6:0] a, input logic rw, input int nb, input logic [7:0] c,
                           input int h1, input int h2, input logic [1:0] bk, input logic [2:0] at,
                           input logic ib, input logic ia, input string req);
        fcap_rec_t e;
        @(negedge clk);
        e.ts = cyc;
        e.txn_id = 16'(next_id);
        next_id++;
        txn_start = 1; bus_idle = ib;
        @(negedge clk);
        txn_start = 0; byte_valid = 1; byte_data = {a, rw};
        for (int i = 0; i < nb; i++) begin
            @(negedge clk);
            byte_data = (i == 0) ? c : 8'($urandom);
        end
        @(negedge clk);
        byte_valid = 0;
        repeat (h1) begin scl_held = 1; @(negedge clk); end
        scl_held = 0;
        @(negedge clk);
        repeat (h2) begin scl_held = 1; @(negedge clk); end
        scl_held = 0; txn_end = 1; end_bucket = bk; end_attempt = at; bus_idle = ia;
        e.addr = a; e.rd = rw;
        e.cmd = (nb > 0) ? c : 8'h00;
        e.len = 8'(nb);
        e.bucket = bk; e.attempt = at;
        e.max_hold = 16'((h1 > h2) ? h1 : h2);
        e.idle_before = ib; e.idle_after = ia;
        @(negedge clk);
        txn_end = 0; end_bucket = 0; bus_idle = 1;
        if (!m_frozen) begin
            m_q.push_back(e);
            if (m_q.size() > DEPTH) void'(m_q.pop_front());
            if (model_hit(e)) m_frozen = 1;
        end
        chk(frozen == m_frozen, {req, " frozen"}, 128'(frozen), 128'(m_frozen));
        chk(rec_count == 4'(m_q.size()), {req, " count"}, 128'(rec_count), 128'(m_q.size()));
    endtask

    task automatic readout(input string req);
        int n = m_q.size();
        for (int i = 0; i <= n; i++) begin
            chk(rd_record == m_q[i % n], $sformatf("%s R2 R8 entry %0d", req, i % n),
                128'(rd_record), 128'(m_q[i % n]));
            rd_step = 1;
            @(negedge clk);
            rd_step = 0;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            failures++;
            checks++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        // R1 reset state
        chk(frozen == 0, "R1 frozen", 128'(frozen), 0);
        chk(rec_count == 0, "R1 count", 128'(rec_count), 0);

        // passing traffic, fills and wraps history (R2 R3 R4 R8)
        for (int k = 0; k < 11; k++) begin
            run_txn(7'($urandom), 1'($urandom), $urandom_range(0, 4), 8'($urandom),
                    $urandom_range(0, 20), $urandom_range(0, 20), 2'b00, 3'($urandom),
                    1'($urandom), 1'($urandom), "R8 fill");
        end
        // boundary: hold equal to limit does not trigger (R5)
        run_txn(7'h11, 1'b0, 1, 8'h22, 20, 3, 2'b00, 3'd1, 1'b1, 1'b1, "R5 at-limit");
        // hold one over the limit triggers (R5)
        run_txn(7'h12, 1'b1, 2, 8'h33, 2, 21, 2'b00, 3'd1, 1'b1, 1'b0, "R5 over-limit");
        // retries after the freeze must not overwrite (R6)
        for (int k = 0; k < 3; k++)
            run_txn(7'h12, 1'b1, 2, 8'h33, 30, 0, 2'b11, 3'(k + 2), 1'b0, 1'b0, "R6 retry");
        readout("R6 R4");

        // R9 re-arm
        rearm = 1;
        @(negedge clk);
        rearm = 0;
        m_q.delete();
        m_frozen = 0;
        @(negedge clk);
        chk(frozen == 0, "R9 frozen", 128'(frozen), 0);
        chk(rec_count == 0, "R9 count", 128'(rec_count), 0);

        // filters: R7 R10
        addr_filt_en = 1; addr_filt = 7'h50;
        run_txn(7'h23, 1'b0, 1, 8'h10, 0, 0, 2'b10, 3'd1, 1'b1, 1'b1, "R10 addr-excluded");
        cmd_filt_en = 1; cmd_filt = 8'h11;
        run_txn(7'h50, 1'b0, 2, 8'h10, 0, 0, 2'b01, 3'd1, 1'b1, 1'b1, "R7 cmd-excluded");
        run_txn(7'h50, 1'b1, 0, 8'h11, 5, 0, 2'b01, 3'd1, 1'b1, 1'b1, "R7 no-cmd-byte");
        run_txn(7'h50, 1'b1, 3, 8'h11, 30, 0, 2'b00, 3'd2, 1'b0, 1'b1, "R7 match");
        // IDs continue across re-arm (R3 R9)
        readout("R3 R9");

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule